// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and gives a product of `2*WIDTH` bits. It uses several cycles and an accumulate-and-shift loop. While the block is idle and `start` is low, it copies both operands into internal registers and holds the accumulator at zero. When `start` rises, a small controller walks the multiplier. On each step, a set low bit adds the widened multiplicand into the accumulator. Every step doubles the multiplicand and halves the multiplier.

The loop ends as soon as the remaining multiplier is zero, so the number of cycles depends on the position of the multiplier's highest set bit. `done` then rises and the product is held. Both stay until the caller drops `start`, and then the block goes back to idle. The asynchronous active-low reset is released synchronously inside the block.

Top module: `seq_shift_add_mult`

## Requirements
- R1: Within three clock edges after reset is deasserted, with `start` low, `done` reads 0 and `product` reads 0.
- R2: In idle with `start` low, `product` reads 0 and `done` reads 0.
- R3: When `done` is 1, `product` equals the unsigned product of the operands that were present on the cycle before `start` was first sampled high (for example, 13 times 11 gives 143).
- R4: Let the posedge that first samples `start` high be edge 1. `done` becomes 1 after edge b+2, where b is the bit length of the multiplier (the index of its highest set bit plus one, or 0 for a zero multiplier).
- R5: While `done` is 1 and `start` stays 1, `done` stays 1 and `product` does not change.
- R6: If `start` is 0 while `done` is 1, `done` is 0 after the next clock edge.
- R7: Changes on `a_in` and `b_in` after `start` has been sampled high have no effect on the product.
- R8: A zero operand on either side gives a product of 0, and a zero multiplier reaches `done` after edge 2.
- R9: Operands that are all ones give (2^WIDTH-1)^2 with no lost bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a multiply; hold high until done is seen |
| a_in | input | WIDTH | Multiplicand operand |
| b_in | input | WIDTH | Multiplier operand |
| product | output | 2*WIDTH | Accumulated product |
| done | output | 1 | Result valid; stays high while start stays high |

## Verification
The bench builds the block with WIDTH = 8. At that width the all-ones case (255 times 255 = 65025) is in reach, and so are multipliers of every bit length from 0 to 8. This lets the bench check the data-dependent completion time for each loop length against the bit-length rule. The 8-bit width also keeps random operand pairs cheap, so many products can be compared against an arithmetic reference in a short run.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mult_state_t;
endpackage

// File: rtl/seq_mult_rst_sync.sv
module seq_mult_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/seq_mult_datapath.sv
module seq_mult_datapath #(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [PW-1:0]    acc,
  output logic             mplier_zero
);
  logic [PW-1:0]    mcand_q, mcand_d;
  logic [WIDTH-1:0] mplier_q, mplier_d;
  logic [PW-1:0]    acc_d;

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc;
    if (load) begin
      mcand_d  = {{WIDTH{1'b0}}, a_in};
      mplier_d = b_in;
      acc_d    = '0;
    end else if (step) begin
      if (mplier_q[0]) acc_d = acc + mcand_q;
      mcand_d  = mcand_q << 1;
      mplier_d = mplier_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc      <= '0;
    end else if (load || step) begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc      <= acc_d;
    end
  end

  assign mplier_zero = (mplier_q == '0);

  // R4: each step halves the remaining multiplier
  p_mplier_halves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> mplier_q == ($past(mplier_q) >> 1));

  // R9: the multiplicand doubles without dropping bits while the multiplier is live
  p_mcand_doubles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> mcand_q == {$past(mcand_q[PW-2:0]), 1'b0});

  // R7: operand registers only move on load or step
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(mcand_q) && $stable(mplier_q) && $stable(acc)));
endmodule

// File: rtl/seq_mult_ctrl.sv
module seq_mult_ctrl
  import seq_mult_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mplier_zero,
  output logic load,
  output logic step,
  output logic done
);
  mult_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)       state_d = ST_RUN;
      ST_RUN:  if (mplier_zero) state_d = ST_DONE;
      ST_DONE: if (!start)      state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign load = (state_q == ST_IDLE) && !start;
  assign step = (state_q == ST_RUN) && !mplier_zero;
  assign done = (state_q == ST_DONE);

  // R5: done persists while start is held
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  // R6: dropping start releases done after one edge
  p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R4: an exhausted multiplier in the loop completes on the next edge
  p_loop_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && mplier_zero) |=> done);
endmodule

// File: rtl/seq_shift_add_mult.sv
module seq_shift_add_mult #(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [PW-1:0]    product,
  output logic             done
);
  logic rst_sync_n;
  logic load, step, mplier_zero;

  seq_mult_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seq_mult_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .mplier_zero (mplier_zero),
    .load        (load),
    .step        (step),
    .done        (done)
  );

  seq_mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load        (load),
    .step        (step),
    .a_in        (a_in),
    .b_in        (b_in),
    .acc         (product),
    .mplier_zero (mplier_zero)
  );

  // R5: the product is frozen while the result is presented and start is held
  p_product_frozen_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && start) |=> $stable(product));
endmodule

// File: tb/seq_shift_add_mult_test.sv
module seq_shift_add_mult_test;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  a_in = '0;
  logic [W-1:0]  b_in = '0;
  logic [PW-1:0] product;
  logic          done;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  seq_shift_add_mult #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a_in), .b_in(b_in), .product(product), .done(done)
  );

  function automatic int bitlen(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one multiply, checks product and completion cycle; optionally scrambles operands mid-run.
  task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit scramble, input string req);
    int n;
    logic [PW-1:0] expv;
    expv = PW'(a) * PW'(b);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({req, " idle product (R2)"}, product, 0);
    check({req, " idle done (R2)"}, done, 0);
    start = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (scramble) begin a_in = ~a; b_in = ~b; end
    end while (!done && n < 4 * W);
    check({req, " latency (R4)"}, n, bitlen(b) + 2);
    check({req, " product (R3)"}, product, expv);
    repeat (3) @(negedge clk);
    check({req, " done held (R5)"}, done, 1);
    check({req, " product held (R5)"}, product, expv);
    start = 1'b0;
    @(negedge clk);
    check({req, " release (R6)"}, done, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("reset done (R1)", done, 0);
    check("reset product (R1)", product, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("post-reset done (R1)", done, 0);
    check("post-reset product (R1)", product, 0);
  endtask

  task automatic t_example();
    run_mult(8'd13, 8'd11, 1'b0, "13x11 R3");
  endtask

  task automatic t_zero();
    run_mult(8'd0, 8'd173, 1'b0, "0xN R8");
    run_mult(8'd201, 8'd0, 1'b0, "Nx0 R8");
    run_mult(8'd0, 8'd0, 1'b0, "0x0 R8");
  endtask

  task automatic t_ones();
    run_mult(8'hFF, 8'hFF, 1'b0, "ones R9");
    run_mult(8'hFF, 8'h01, 1'b0, "ones-by-one R9");
  endtask

  task automatic t_lengths();
    for (int k = 0; k < W; k++) run_mult(8'd37, W'(1) << k, 1'b0, "single-bit R4");
  endtask

  task automatic t_scramble();
    run_mult(8'd91, 8'd150, 1'b1, "scramble R7");
    run_mult(8'd7, 8'd3, 1'b1, "scramble short R7");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom());
      rb = W'($urandom());
      run_mult(ra, rb, 1'b0, "random R3");
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired (R4) actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_example();
    t_zero();
    t_ones();
    t_lengths();
    t_scramble();
    t_random();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule